// File: doc/BRIEF.md
# Brown-out and Reset Status Controller

This block holds the reset-cause record and the brown-out interrupt logic of a small microcontroller. Four sticky flags record why the chip last restarted: the external pin, the watchdog, the debugger or the brown-out detector. An analog comparator bank, outside this block, supplies five voltage-level indicators as synchronous digital inputs. Each indicator reads 1 while the supply is below its threshold. The indicators pass through a two-flop synchroniser. A 3-bit code then picks one of them to drive a brown-out interrupt flag.

Software reaches the block through an 8-bit register bus with two addresses: a control register and a status register. The select code is split across the two registers. The flag can be raised on a level or on a rising indicator, which is a falling supply. A stop-mode input switches the detector off while it is active. When stop mode ends, the stored enable bit takes effect again. Every flag is cleared by writing 0 to its bit. If a hardware set and a clear fall in the same cycle, the set wins.

Top module: `bod_rst_ctrl`

## Requirements
- R1: A synchronous reset loads the control register (address 0) with 00h, or with D9h if `dbg_mode_i` is high during reset. The status register (address 1) reads 00h after reset.
- R2: In the control register, bit 7 is the debugger cause flag, bit 6 external, bit 4 watchdog and bit 3 brown-out. Each flag is set by its event input and stays set until a write of 0 to that bit. Writing 1 leaves the flag unchanged.
- R3: When an event and a write of 0 to its flag fall in the same cycle, the flag ends up set.
- R4: Control bit 0 is the detector enable and bits 2:1 are the low select bits. Both read back what was written. Bit 5 always reads 0.
- R5: Status bit 6 is select bit 2 and bit 5 is the trigger type (0 level, 1 edge). Both are read/write. Bits 4..0 show indicators 0, 4, 3, 2, 1 in that order, two clocks after `lvl_i` changes. Writes to bits 4..0 have no effect.
- R6: Status bit 4 (indicator 0) reads 0 unless select bit 2 is 1. Status bit 3 (indicator 4) reads 0 unless the select code is 011.
- R7: The select code {status bit 6, control bits 2:1} chooses the indicator: 1xx gives indicator 0, 000 indicator 1, 001 indicator 2, 010 indicator 3, 011 indicator 4. The other indicators do not raise the flag.
- R8: In level mode the interrupt flag (status bit 7) is set on every clock in which the detector is enabled and the synchronised selected indicator is 1.
- R9: In edge mode the flag is set only when the synchronised selected indicator goes from 0 to 1. An indicator that stays at 1 does not set it again after a clear.
- R10: Writing 0 to status bit 7 clears the flag. Writing 1 never sets it. A hardware set in the same cycle as the clear wins.
- R11: The effective enable is the enable bit ANDed with the inverse of `stop_i`. While it is 0, the flag is never set.
- R12: `irq_o` equals the interrupt flag ANDed with the effective enable.
- R13: In edge mode, an indicator that rose while the detector was disabled does not raise the flag when the detector is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_mode_i | input | 1 | Debug mode; selects the control register reset value |
| stop_i | input | 1 | Stop mode active; disables the detector |
| evt_ext_i | input | 1 | External pin reset event |
| evt_wdt_i | input | 1 | Watchdog reset event |
| evt_dbg_i | input | 1 | Debugger reset event |
| evt_bod_i | input | 1 | Brown-out reset event |
| lvl_i | input | 5 | Voltage indicators 0..4, 1 = supply below threshold |
| addr_i | input | 1 | Register select: 0 control, 1 status |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | Brown-out interrupt request |

## Verification
Each select code is tried with only the selected indicator high and then with every other indicator high. This shows whether the code steers the correct input or merely passes some input. The level and edge modes are both tried with an indicator that stays high across a clear: level mode must set the flag again and edge mode must not. Stop mode is applied while an indicator rises and then released with the indicator still high. This separates gating of the flag set from gating of the edge history. A clear and an event in the same cycle show which of the two takes priority.

// File: rtl/bod_pkg.sv
package bod_pkg;
    localparam int NUM_IND   = 5;
    localparam int NUM_CAUSE = 4;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = $clog2(NUM_IND);

    localparam logic [DATA_W-1:0] CTRL_RST_NORM = 8'h00;
    localparam logic [DATA_W-1:0] CTRL_RST_DBG  = 8'hD9;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    localparam int CAUSE_EXT = 0;
    localparam int CAUSE_WDT = 1;
    localparam int CAUSE_DBG = 2;
    localparam int CAUSE_BOD = 3;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

    typedef struct packed {
        logic       dbg;
        logic       ext;
        logic       rsv;
        logic       wdt;
        logic       bod;
        logic [1:0] sel;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic  flag;
        logic  sel2;
        trig_e trig;
        logic  ind0;
        logic  ind4;
        logic  ind3;
        logic  ind2;
        logic  ind1;
    } stat_t;

    function automatic logic [IDX_W-1:0] ind_index(input logic [2:0] code);
        if (code[2])
            return '0;
        return IDX_W'(code[1:0]) + IDX_W'(1);
    endfunction
endpackage

// File: rtl/bod_sync.sv
module bod_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/bod_sticky.sv
module bod_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] rst_val_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q_o[g] <= rst_val_i[g];
            else if (set_i[g])
                q_o[g] <= 1'b1;
            else if (clr_i[g])
                q_o[g] <= 1'b0;
        end

        // R2
        sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && $past(set_i[g]) |-> q_o[g]);

        // R3
        sticky_fall_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && $fell(q_o[g]) |-> $past(clr_i[g]) && !$past(set_i[g]));
    end
endmodule

// File: rtl/bod_detect.sv
module bod_detect
    import bod_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IND-1:0] ind_i,
    input  logic [2:0]         code_i,
    input  trig_e              trig_i,
    input  logic               en_eff_i,
    output logic               set_o,
    output logic               sel_ind_o
);
    logic hist_q;

    always_comb begin
        sel_ind_o = ind_i[ind_index(code_i)];
        set_o     = en_eff_i && sel_ind_o && (trig_i == TRIG_LEVEL || !hist_q);
    end

    // history follows the selected indicator every cycle, enabled or not
    always_ff @(posedge clk) begin
        if (rst)
            hist_q <= 1'b0;
        else
            hist_q <= sel_ind_o;
    end

    // R9
    edge_once_chk: assert property (@(posedge clk) disable iff (rst)
        trig_i == TRIG_EDGE && set_o && $stable(code_i) |=> trig_i == TRIG_LEVEL || !set_o || $changed(code_i));

    // R13
    no_false_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(en_eff_i) && en_eff_i && trig_i == TRIG_EDGE
        && $past(sel_ind_o) && $stable(code_i) |-> !set_o);
endmodule

// File: rtl/bod_rst_ctrl.sv
module bod_rst_ctrl
    import bod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_mode_i,
    input  logic              stop_i,
    input  logic              evt_ext_i,
    input  logic              evt_wdt_i,
    input  logic              evt_dbg_i,
    input  logic              evt_bod_i,
    input  logic [NUM_IND-1:0] lvl_i,
    input  logic              addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    ctrl_t rst_ctrl;
    ctrl_t wr_ctrl;
    stat_t wr_stat;
    ctrl_t rd_ctrl;
    stat_t rd_stat;

    logic wr_ctrl_en;
    logic wr_stat_en;

    logic       en_q;
    logic [1:0] sel_q;
    logic       sel2_q;
    trig_e      trig_q;
    logic       en_eff;
    logic [2:0] code;

    logic [NUM_IND-1:0]   ind_s;
    logic [NUM_CAUSE-1:0] cause_rst;
    logic [NUM_CAUSE-1:0] cause_set;
    logic [NUM_CAUSE-1:0] cause_clr;
    logic [NUM_CAUSE-1:0] cause_q;

    logic flag_set;
    logic flag_clr;
    logic flag_q;
    logic sel_ind;

    assign rst_ctrl   = ctrl_t'(dbg_mode_i ? CTRL_RST_DBG : CTRL_RST_NORM);
    assign wr_ctrl    = ctrl_t'(wdata_i);
    assign wr_stat    = stat_t'(wdata_i);
    assign wr_ctrl_en = we_i && (addr_i == ADDR_CTRL);
    assign wr_stat_en = we_i && (addr_i == ADDR_STAT);

    // writable control and configuration fields
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= rst_ctrl.en;
            sel_q  <= rst_ctrl.sel;
            sel2_q <= 1'b0;
            trig_q <= TRIG_LEVEL;
        end else begin
            if (wr_ctrl_en) begin
                en_q  <= wr_ctrl.en;
                sel_q <= wr_ctrl.sel;
            end
            if (wr_stat_en) begin
                sel2_q <= wr_stat.sel2;
                trig_q <= wr_stat.trig;
            end
        end
    end

    assign code   = {sel2_q, sel_q};
    assign en_eff = en_q && !stop_i;

    // reset-cause flags
    always_comb begin
        cause_rst[CAUSE_EXT] = rst_ctrl.ext;
        cause_rst[CAUSE_WDT] = rst_ctrl.wdt;
        cause_rst[CAUSE_DBG] = rst_ctrl.dbg;
        cause_rst[CAUSE_BOD] = rst_ctrl.bod;
        cause_set[CAUSE_EXT] = evt_ext_i;
        cause_set[CAUSE_WDT] = evt_wdt_i;
        cause_set[CAUSE_DBG] = evt_dbg_i;
        cause_set[CAUSE_BOD] = evt_bod_i;
        cause_clr[CAUSE_EXT] = wr_ctrl_en && !wr_ctrl.ext;
        cause_clr[CAUSE_WDT] = wr_ctrl_en && !wr_ctrl.wdt;
        cause_clr[CAUSE_DBG] = wr_ctrl_en && !wr_ctrl.dbg;
        cause_clr[CAUSE_BOD] = wr_ctrl_en && !wr_ctrl.bod;
    end

    bod_sticky #(.N(NUM_CAUSE)) u_cause (
        .clk       (clk),
        .rst       (rst),
        .rst_val_i (cause_rst),
        .set_i     (cause_set),
        .clr_i     (cause_clr),
        .q_o       (cause_q)
    );

    // indicator path
    bod_sync #(.W(NUM_IND)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (lvl_i),
        .q_o (ind_s)
    );

    bod_detect u_detect (
        .clk       (clk),
        .rst       (rst),
        .ind_i     (ind_s),
        .code_i    (code),
        .trig_i    (trig_q),
        .en_eff_i  (en_eff),
        .set_o     (flag_set),
        .sel_ind_o (sel_ind)
    );

    assign flag_clr = wr_stat_en && !wr_stat.flag;

    bod_sticky #(.N(1)) u_flag (
        .clk       (clk),
        .rst       (rst),
        .rst_val_i (1'b0),
        .set_i     (flag_set),
        .clr_i     (flag_clr),
        .q_o       (flag_q)
    );

    // read path
    always_comb begin
        rd_ctrl     = '0;
        rd_ctrl.dbg = cause_q[CAUSE_DBG];
        rd_ctrl.ext = cause_q[CAUSE_EXT];
        rd_ctrl.wdt = cause_q[CAUSE_WDT];
        rd_ctrl.bod = cause_q[CAUSE_BOD];
        rd_ctrl.sel = sel_q;
        rd_ctrl.en  = en_q;

        rd_stat      = '0;
        rd_stat.flag = flag_q;
        rd_stat.sel2 = sel2_q;
        rd_stat.trig = trig_q;
        rd_stat.ind0 = sel2_q && ind_s[0];
        rd_stat.ind4 = (code == 3'b011) && ind_s[4];
        rd_stat.ind3 = ind_s[3];
        rd_stat.ind2 = ind_s[2];
        rd_stat.ind1 = ind_s[1];

        rdata_o = (addr_i == ADDR_CTRL) ? DATA_W'(rd_ctrl) : DATA_W'(rd_stat);
    end

    assign irq_o = flag_q && en_eff;

    // R11
    flag_rise_en_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $rose(flag_q) |-> $past(en_eff));

    // R8
    flag_rise_ind_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $rose(flag_q) |-> $past(sel_ind));

    // R12
    irq_stop_chk: assert property (@(posedge clk) disable iff (rst)
        stop_i |-> !irq_o);

    // R6
    ind0_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        addr_i == ADDR_STAT && !sel2_q |-> !rdata_o[4]);
endmodule

// File: tb/tb_bod_rst_ctrl.sv
`timescale 1ns/1ps
module tb_bod_rst_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dbg_mode = 1'b1;
    logic       stop = 1'b0;
    logic       e_ext = 1'b0, e_wdt = 1'b0, e_dbg = 1'b0, e_bod = 1'b0;
    logic [4:0] lvl = '0;
    logic       addr = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    bod_rst_ctrl dut (
        .clk(clk), .rst(rst), .dbg_mode_i(dbg_mode), .stop_i(stop),
        .evt_ext_i(e_ext), .evt_wdt_i(e_wdt), .evt_dbg_i(e_dbg), .evt_bod_i(e_bod),
        .lvl_i(lvl), .addr_i(addr), .we_i(we), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    // behavioural reference model
    bit m_ok = 0;
    bit m_ext, m_wdt, m_dbg, m_bod, m_en, m_sel2, m_trig, m_flag, m_hist;
    bit [1:0] m_sel;
    bit [4:0] pipe[$];

    always @(posedge clk) begin
        if (rst) begin
            {m_dbg, m_ext, m_wdt, m_bod, m_en} = dbg_mode ? 5'b11111 : 5'b00000;
            m_sel = 2'b00; m_sel2 = 0; m_trig = 0; m_flag = 0; m_hist = 0;
            pipe = '{5'b0, 5'b0};
            m_ok = 1;
        end else if (m_ok) begin
            int idx;
            bit seli, setf, wc, ws;
            idx  = m_sel2 ? 0 : int'(m_sel) + 1;
            seli = pipe[0][idx];
            setf = m_en && !stop && seli && (!m_trig || !m_hist);
            wc   = we && !addr;
            ws   = we && addr;
            if (setf) m_flag = 1; else if (ws && !wdata[7]) m_flag = 0;
            if (e_ext) m_ext = 1; else if (wc && !wdata[6]) m_ext = 0;
            if (e_wdt) m_wdt = 1; else if (wc && !wdata[4]) m_wdt = 0;
            if (e_dbg) m_dbg = 1; else if (wc && !wdata[7]) m_dbg = 0;
            if (e_bod) m_bod = 1; else if (wc && !wdata[3]) m_bod = 0;
            if (wc) begin m_en = wdata[0]; m_sel = wdata[2:1]; end
            if (ws) begin m_sel2 = wdata[6]; m_trig = wdata[5]; end
            m_hist = seli;
            void'(pipe.pop_front());
            pipe.push_back(lvl);
        end
    end

    function automatic logic [7:0] model_rd(input logic a);
        logic [4:0] s;
        s = pipe[0];
        if (!a)
            return {m_dbg, m_ext, 1'b0, m_wdt, m_bod, m_sel, m_en};
        return {m_flag, m_sel2, m_trig, m_sel2 & s[0],
                ({m_sel2, m_sel} == 3'b011) & s[4], s[3], s[2], s[1]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (m_ok && !rst) begin
            chk(rdata === model_rd(addr), "R2/R5 model rdata", rdata, model_rd(addr));
            chk(irq === (m_flag && m_en && !stop), "R12 model irq",
                {7'b0, irq}, {7'b0, m_flag && m_en && !stop});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); #1;
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rdchk(input logic a, input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        addr = a;
        #0.5;
        chk(rdata === exp, tag, rdata, exp);
    endtask

    task automatic do_reset(input logic dm);
        @(negedge clk); #1;
        dbg_mode = dm; rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    initial begin
        idle(2);
        rst = 1'b0;
        // R1 debug reset value
        rdchk(0, 8'hD9, "R1 debug reset ctrl");
        rdchk(1, 8'h00, "R1 debug reset status");
        do_reset(1'b0);
        rdchk(0, 8'h00, "R1 normal reset ctrl");

        // R2 sticky flags, write 1 keeps, write 0 clears
        @(negedge clk); #1; e_ext = 1; @(negedge clk); #1; e_ext = 0;
        rdchk(0, 8'h40, "R2 ext flag set");
        wr(0, 8'hFF);
        rdchk(0, 8'h47, "R2 write 1 keeps flag, R4 fields and rsv zero");
        wr(0, 8'h00);
        rdchk(0, 8'h00, "R2 write 0 clears");
        @(negedge clk); #1; e_dbg = 1; e_wdt = 1; e_bod = 1;
        @(negedge clk); #1; e_dbg = 0; e_wdt = 0; e_bod = 0;
        rdchk(0, 8'h98, "R2 dbg wdt bod flags");
        // R3 set wins over clear
        @(negedge clk); #1; addr = 0; wdata = 8'h00; we = 1; e_wdt = 1;
        @(negedge clk); #1; we = 0; e_wdt = 0;
        rdchk(0, 8'h10, "R3 set beats clear");

        // R8 level mode on indicator 1
        wr(0, 8'h01);
        wr(1, 8'h00);
        lvl = 5'b00010; idle(4);
        rdchk(1, 8'h81, "R8 level flag, R5 ind1 bit");
        chk(irq === 1'b1, "R12 irq high", {7'b0, irq}, 8'h01);
        wr(1, 8'h00);
        rdchk(1, 8'h81, "R10 clear loses to level set");
        lvl = 5'b0; idle(3);
        wr(1, 8'h00);
        rdchk(1, 8'h00, "R10 clear by write 0");
        wr(1, 8'h80);
        rdchk(1, 8'h00, "R10 write 1 does not set");

        // R9 edge mode
        wr(1, 8'h20);
        lvl = 5'b00010; idle(4);
        rdchk(1, 8'hA1, "R9 edge sets flag");
        wr(1, 8'h20); idle(3);
        rdchk(1, 8'h21, "R9 held indicator no re-set");
        lvl = 5'b0; idle(3);
        lvl = 5'b00010; idle(4);
        rdchk(1, 8'hA1, "R9 second edge");

        // R11 / R13 stop mode
        wr(1, 8'h20);
        lvl = 5'b0; idle(3);
        stop = 1; lvl = 5'b00010; idle(4);
        rdchk(1, 8'h21, "R11 no set in stop");
        chk(irq === 1'b0, "R11 irq low in stop", {7'b0, irq}, 8'h00);
        stop = 0; idle(3);
        rdchk(1, 8'h21, "R13 no false edge after stop");
        wr(1, 8'h00); idle(2);
        rdchk(1, 8'h81, "R11 enable restored, level set");
        @(negedge clk); #1; stop = 1; #0.5;
        chk(irq === 1'b0, "R12 irq masked by stop", {7'b0, irq}, 8'h00);
        rdchk(1, 8'h81, "R12 flag kept during stop");
        stop = 0;

        // R7 / R6 select codes
        for (int idx = 0; idx < 5; idx++) begin
            logic s2;
            logic [1:0] sl;
            logic [4:0] v;
            logic [7:0] e;
            s2 = (idx == 0);
            sl = (idx == 0) ? 2'b00 : 2'(idx - 1);
            lvl = 5'b0; idle(3);
            wr(1, {1'b0, s2, 6'b0});
            wr(0, {5'b0, sl, 1'b1});
            v = ~(5'b1 << idx);
            lvl = v; idle(4);
            e = {1'b0, s2, 1'b0, s2 & v[0], (idx == 4) & v[4], v[3], v[2], v[1]};
            rdchk(1, e, "R7 unselected indicators no flag");
            lvl = 5'b1 << idx; idle(4);
            @(negedge clk); #1; addr = 1; #0.5;
            chk(rdata[7] === 1'b1, "R7 selected indicator sets flag", rdata, {1'b1, rdata[6:0]});
            lvl = 5'h1F; idle(3);
            rdchk(1, {1'b1, s2, 1'b0, s2, idx == 4, 3'b111}, "R6 ind0 ind4 reporting");
        end

        // R5 indicator bits ignore writes
        lvl = 5'b0; idle(3);
        wr(1, 8'h1F);
        rdchk(1, 8'h00, "R5 indicator bits not writable");

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule